// File: doc/BRIEF.md
# Speculative L1 Line State Controller

This block keeps the per-line bookkeeping of a private first-level cache used by one processor running speculative epochs. It is direct-mapped, write-through and no-write-allocate. Next to each tag it stores a valid bit and three speculation bits: a loaded bit (the shared cache has already been told that this epoch read the line), a modified bit (the line holds speculative writes) and a stale bit (the line may be out of date relative to speculative work). The block decides hit or miss for each processor request from these bits, allocates lines on load misses, and forwards every store downstream on a write-through port.

The processor can commit or violate the current epoch with a one-cycle command. Both act on every line at once, as flash operations on the bit columns. The processor can also escape speculation to make changes that the whole system sees. While escaped, lines holding speculative writes are hidden from the tag match. The first speculative load of each line in an epoch pushes the line address into a small notification queue toward the shared cache. When that queue is full, such a load stalls the processor.

Top module: `spl1_line_ctrl`

## Requirements
- R1: After reset no line is valid. A load that misses allocates its line, so the next load to the same address hits.
- R2: A speculative load (`spec_on`=1, `escaped`=0) to a line whose loaded bit is clear pushes that line address into the notification queue and sets the loaded bit. Later loads of the same line push nothing. A load with `spec_on`=0 never pushes.
- R3: The notification queue holds `NTF_DEPTH` (4) entries and delivers them in arrival order. While `ntf_valid`=1 and `ntf_ready`=0, the head address stays put. When the queue is full, a load that needs a notification sees `req_ready`=0 until a slot frees.
- R4: Every accepted store shows its address on `wt_addr` with `wt_valid`=1 in the same cycle. A store miss allocates nothing, so a later load of that address misses.
- R5: A speculative store that hits sets the modified bit. `commit_i` clears the loaded, modified and stale bits of all lines and keeps them valid, so the next speculative load of a committed line hits and notifies again.
- R6: `violate_i` invalidates every line whose modified bit is set, keeps the other lines valid, and clears all loaded and stale bits.
- R7: While `escaped`=1, any access that matches a line with the modified bit set reports a miss. It allocates nothing, leaves the modified bit unchanged and sets the line's stale bit.
- R8: With `escaped`=0, an access that matches a stale line reports a miss. A load refills the line, which clears the stale bit so the next load hits. A store invalidates the line. Commit clears the stale bit.
- R9: In any cycle where `commit_i` or `violate_i` is high, `req_ready` is 0 and no request is accepted.
- R10: Loads issued while `escaped`=1 never push a notification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Line address; the low log2(LINES) bits select the line |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| resp_hit | output | 1 | Accepted request hit |
| spec_on | input | 1 | Processor is running a speculative epoch |
| escaped | input | 1 | Processor has escaped speculation |
| commit_i | input | 1 | Commit the epoch (one-cycle pulse) |
| violate_i | input | 1 | Violate the epoch (one-cycle pulse) |
| wt_valid | output | 1 | Write-through store forwarded downstream |
| wt_addr | output | ADDR_W | Address of the forwarded store |
| ntf_valid | output | 1 | Notification queue not empty |
| ntf_ready | input | 1 | Downstream takes the head notification |
| ntf_addr | output | ADDR_W | Line address at the queue head |

## Verification
The hardest state to reach is a line that is valid, modified and stale at the same time. From there the next non-escaped store must invalidate the line and the next load must refill it. The bench reaches this state in steps: a speculative load allocates the line, a speculative store marks it modified, and an escaped access to the same address marks it stale. Only then does the bench drop the escape and issue the store or load. A full notification queue is reached by holding `ntf_ready` low across four speculative loads to distinct lines. A fifth load is then offered to see the stall, and the queue is drained to check the order.

// File: rtl/spl1_pkg.sv
package spl1_pkg;

  typedef struct packed {
    logic vld;
    logic sl;
    logic sm;
    logic stl;
  } line_bits_t;

endpackage

// File: rtl/spl1_tag_store.sv
module spl1_tag_store
  import spl1_pkg::*;
#(
  parameter int LINES = 8,
  parameter int TAG_W = 9,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output line_bits_t       rd_bits,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_bits_t       wr_bits,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             fl_commit,
  input  logic             fl_violate
);

  line_bits_t       bits [LINES];
  logic [TAG_W-1:0] tags [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bits[i] <= '0;
        tags[i] <= '0;
      end else if (fl_violate) begin
        bits[i].vld <= bits[i].vld & ~bits[i].sm;
        bits[i].sl  <= 1'b0;
        bits[i].sm  <= 1'b0;
        bits[i].stl <= 1'b0;
      end else if (fl_commit) begin
        bits[i].sl  <= 1'b0;
        bits[i].sm  <= 1'b0;
        bits[i].stl <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        bits[i] <= wr_bits;
        tags[i] <= wr_tag;
      end
    end
  end

  assign rd_bits = bits[rd_idx];
  assign rd_tag  = tags[rd_idx];

endmodule

// File: rtl/spl1_notify_fifo.sv
module spl1_notify_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 12,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              not_empty,
  output logic              full,
  output logic [DATA_W-1:0] head
);

  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign not_empty = (cnt != '0);
  assign full      = (cnt == CNT_W'(DEPTH));
  assign do_push   = push && !full;
  assign do_pop    = pop && not_empty;
  assign head      = slots[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= ptr_next(wp);
      if (do_pop)  rp <= ptr_next(rp);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slots[i] <= '0;
      else if (do_push && (wp == PTR_W'(i))) slots[i] <= push_data;
    end
  end

endmodule

// File: rtl/spl1_line_ctrl.sv
module spl1_line_ctrl
  import spl1_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LINES     = 8,
  parameter int NTF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_hit,
  input  logic              spec_on,
  input  logic              escaped,
  input  logic              commit_i,
  input  logic              violate_i,
  output logic              wt_valid,
  output logic [ADDR_W-1:0] wt_addr,
  output logic              ntf_valid,
  input  logic              ntf_ready,
  output logic [ADDR_W-1:0] ntf_addr
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] line_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] line_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  line_bits_t       rd_bits, wr_bits;
  logic [TAG_W-1:0] rd_tag;
  logic             wr_en;

  // named events for the checker
  logic tag_match, ev_esc_mask, ev_stale_mask, eff_hit;
  logic need_ntf, ev_ntf_push, ntf_full, cmd_any, fire;

  assign tag_match     = rd_bits.vld && (rd_tag == line_tag(req_addr));
  assign ev_esc_mask   = escaped && tag_match && rd_bits.sm;
  assign ev_stale_mask = !escaped && tag_match && rd_bits.stl;
  assign eff_hit       = tag_match && !ev_esc_mask && !ev_stale_mask;
  assign need_ntf      = !req_store && spec_on && !escaped
                         && !(tag_match && rd_bits.sl);
  assign cmd_any       = commit_i || violate_i;
  assign req_ready     = !cmd_any && !(need_ntf && ntf_full);
  assign fire          = req_valid && req_ready;
  assign ev_ntf_push   = fire && need_ntf;

  assign resp_hit = fire && eff_hit;
  assign wt_valid = fire && req_store;
  assign wt_addr  = req_addr;

  always_comb begin
    wr_en   = 1'b0;
    wr_bits = rd_bits;
    if (fire) begin
      if (ev_esc_mask) begin
        wr_en       = 1'b1;
        wr_bits.stl = 1'b1;
      end else if (!req_store) begin
        wr_en       = 1'b1;
        wr_bits.vld = 1'b1;
        wr_bits.sl  = (tag_match && rd_bits.sl) || need_ntf;
        wr_bits.sm  = tag_match && rd_bits.sm;
        wr_bits.stl = eff_hit && rd_bits.stl;
      end else if (ev_stale_mask) begin
        wr_en       = 1'b1;
        wr_bits     = '0;
      end else if (eff_hit) begin
        wr_en       = 1'b1;
        wr_bits.sm  = rd_bits.sm || (spec_on && !escaped);
      end
    end
  end

  spl1_tag_store #(
    .LINES (LINES),
    .TAG_W (TAG_W)
  ) tags_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (line_idx(req_addr)),
    .rd_bits    (rd_bits),
    .rd_tag     (rd_tag),
    .wr_en      (wr_en),
    .wr_idx     (line_idx(req_addr)),
    .wr_bits    (wr_bits),
    .wr_tag     (line_tag(req_addr)),
    .fl_commit  (commit_i),
    .fl_violate (violate_i)
  );

  spl1_notify_fifo #(
    .DEPTH  (NTF_DEPTH),
    .DATA_W (ADDR_W)
  ) ntf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_ntf_push),
    .push_data (req_addr),
    .pop       (ntf_ready),
    .not_empty (ntf_valid),
    .full      (ntf_full),
    .head      (ntf_addr)
  );

endmodule

// File: rtl/spl1_line_ctrl_chk.sv
module spl1_line_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit_i,
  input logic              violate_i,
  input logic              req_ready,
  input logic              resp_hit,
  input logic              ev_ntf_push,
  input logic              ntf_full,
  input logic              ev_esc_mask,
  input logic              ev_stale_mask,
  input logic              escaped,
  input logic              ntf_valid,
  input logic              ntf_ready,
  input logic [ADDR_W-1:0] ntf_addr
);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ntf_push |-> !ntf_full);

  a_r3_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && !ntf_ready) |=> (ntf_valid && $stable(ntf_addr)));

  a_r9_cmd_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i || violate_i) |-> !req_ready);

  a_r7_masked_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ev_esc_mask |-> !resp_hit);

  a_r8_stale_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stale_mask |-> !resp_hit);

  a_r10_no_escaped_push: assert property (@(posedge clk) disable iff (!rst_n)
    escaped |-> !ev_ntf_push);

endmodule

bind spl1_line_ctrl spl1_line_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .commit_i      (commit_i),
  .violate_i     (violate_i),
  .req_ready     (req_ready),
  .resp_hit      (resp_hit),
  .ev_ntf_push   (ev_ntf_push),
  .ntf_full      (ntf_full),
  .ev_esc_mask   (ev_esc_mask),
  .ev_stale_mask (ev_stale_mask),
  .escaped       (escaped),
  .ntf_valid     (ntf_valid),
  .ntf_ready     (ntf_ready),
  .ntf_addr      (ntf_addr)
);

// File: tb/spl1_line_ctrl_tb.sv
`timescale 1ns/1ps
module spl1_line_ctrl_tb_top;

  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_store = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, resp_hit;
  logic          spec_on = 1'b0, escaped = 1'b0;
  logic          commit_i = 1'b0, violate_i = 1'b0;
  logic          wt_valid;
  logic [AW-1:0] wt_addr;
  logic          ntf_valid;
  logic          ntf_ready = 1'b0;
  logic [AW-1:0] ntf_addr;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  spl1_line_ctrl #(.ADDR_W(AW), .LINES(8), .NTF_DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_ready(req_ready), .resp_hit(resp_hit),
    .spec_on(spec_on), .escaped(escaped), .commit_i(commit_i),
    .violate_i(violate_i), .wt_valid(wt_valid), .wt_addr(wt_addr),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_addr(ntf_addr)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // one request; result sampled before the accepting edge
  task automatic access(input bit st, input logic [AW-1:0] a,
                        output bit rdy, output bit hit,
                        output bit wv, output logic [AW-1:0] wa);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_addr = a;
    #1;
    rdy = req_ready; hit = resp_hit; wv = wt_valid; wa = wt_addr;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic load_chk(input logic [AW-1:0] a, input bit exp_hit, input string rq);
    bit r, h, w; logic [AW-1:0] wa;
    access(1'b0, a, r, h, w, wa);
    chk(r && (h == exp_hit), rq, {r, h}, {1'b1, exp_hit});
  endtask

  task automatic store_chk(input logic [AW-1:0] a, input bit exp_hit, input string rq);
    bit r, h, w; logic [AW-1:0] wa;
    access(1'b1, a, r, h, w, wa);
    chk(r && (h == exp_hit), rq, {r, h}, {1'b1, exp_hit});
    chk(w && (wa == a), "R4 write-through", int'(wa), int'(a));
  endtask

  task automatic ntf_chk(input bit exp_v, input string rq);
    @(negedge clk);
    #1 chk(ntf_valid == exp_v, rq, ntf_valid, exp_v);
  endtask

  task automatic pop_chk(input logic [AW-1:0] exp_a, input string rq);
    @(negedge clk);
    #1 chk(ntf_valid && (ntf_addr == exp_a), rq, int'(ntf_addr), int'(exp_a));
    ntf_ready = 1'b1;
    @(posedge clk);
    #1 ntf_ready = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!ntf_valid) break;
      ntf_ready = 1'b1;
      @(posedge clk);
      #1 ntf_ready = 1'b0;
    end
  endtask

  task automatic pulse_cmd(input bit viol, input string rq);
    @(negedge clk);
    commit_i = !viol; violate_i = viol;
    req_valid = 1'b1; req_store = 1'b0; req_addr = 12'hFFF;
    #1 chk(req_ready == 1'b0, rq, req_ready, 0);
    @(posedge clk);
    #1 begin commit_i = 0; violate_i = 0; req_valid = 0; end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ntf_valid == 1'b0, "R3 reset queue empty", ntf_valid, 0);
    load_chk(12'h005, 1'b0, "R1 reset miss");
    load_chk(12'h005, 1'b1, "R1 hit after alloc");
    ntf_chk(1'b0, "R2 non-spec no notify");
  endtask

  task automatic t_notify();
    spec_on = 1'b1;
    load_chk(12'h0E1, 1'b0, "R2 spec miss");
    ntf_chk(1'b1, "R2 first load notifies");
    load_chk(12'h0E1, 1'b1, "R2 spec re-hit");
    pop_chk(12'h0E1, "R2 notify address");
    ntf_chk(1'b0, "R2 only one notice");
  endtask

  task automatic t_fifo_full();
    bit r, h, w; logic [AW-1:0] wa;
    for (int i = 0; i < 4; i++) load_chk(AW'(12'h100 + i), 1'b0, "R3 fill");
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_addr = 12'h104;
    #1 chk(req_ready == 1'b0, "R3 stall when full", req_ready, 0);
    @(posedge clk);
    #1 req_valid = 1'b0;
    chk(ntf_addr == 12'h100, "R3 head held", int'(ntf_addr), 'h100);
    pop_chk(12'h100, "R3 order 0");
    access(1'b0, 12'h104, r, h, w, wa);
    chk(r == 1'b1, "R3 accepted after slot frees", r, 1);
    for (int i = 1; i < 5; i++) pop_chk(AW'(12'h100 + i), "R3 order");
    ntf_chk(1'b0, "R3 drained");
  endtask

  task automatic t_store();
    spec_on = 1'b0;
    store_chk(12'h0A2, 1'b0, "R4 store miss");
    load_chk(12'h0A2, 1'b0, "R4 no write-allocate");
    spec_on = 1'b1;
    drain();
  endtask

  task automatic t_commit();
    load_chk(12'h1F4, 1'b0, "R5 spec load");
    drain();
    store_chk(12'h1F4, 1'b1, "R5 spec store hit");
    pulse_cmd(1'b0, "R9 commit blocks request");
    load_chk(12'h1F4, 1'b1, "R5 valid after commit");
    ntf_chk(1'b1, "R5 renotify after commit");
    drain();
  endtask

  task automatic t_violate();
    load_chk(12'h208, 1'b0, "R6 setup D");
    store_chk(12'h208, 1'b1, "R6 store D");
    load_chk(12'h20B, 1'b0, "R6 setup E");
    drain();
    pulse_cmd(1'b1, "R9 violate blocks request");
    load_chk(12'h20B, 1'b1, "R6 clean line kept");
    ntf_chk(1'b1, "R6 loaded bit cleared");
    load_chk(12'h208, 1'b0, "R6 modified line dropped");
    drain();
  endtask

  task automatic t_escape();
    load_chk(12'h305, 1'b0, "R7 setup");
    store_chk(12'h305, 1'b1, "R7 spec store");
    drain();
    escaped = 1'b1;
    load_chk(12'h305, 1'b0, "R7 escaped hides modified");
    load_chk(12'h317, 1'b0, "R10 escaped miss");
    load_chk(12'h317, 1'b1, "R10 escaped alloc");
    ntf_chk(1'b0, "R10 no escaped notify");
    escaped = 1'b0;
    load_chk(12'h305, 1'b0, "R8 stale load miss");
    load_chk(12'h305, 1'b1, "R8 refill clears stale");
    ntf_chk(1'b0, "R2 loaded bit kept on refill");
    escaped = 1'b1;
    store_chk(12'h305, 1'b0, "R7 escaped store miss");
    escaped = 1'b0;
    store_chk(12'h305, 1'b0, "R8 stale store miss");
    load_chk(12'h305, 1'b0, "R8 stale store invalidates");
    drain();
    load_chk(12'h306, 1'b0, "R8 setup H");
    store_chk(12'h306, 1'b1, "R8 store H");
    escaped = 1'b1;
    load_chk(12'h306, 1'b0, "R7 mark H stale");
    escaped = 1'b0;
    pulse_cmd(1'b0, "R9 commit");
    load_chk(12'h306, 1'b1, "R8 commit clears stale");
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_notify();
    t_fifo_full();
    t_store();
    t_commit();
    t_violate();
    t_escape();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule